// File: doc/BRIEF.md
# Triple Match-Compare Timer

This peripheral holds three independent 32-bit counters behind a small register bus that follows the APB two-phase access pattern. Each counter has a live value, a reload value and two compare values. It advances on the bus clock or on rising edges of its own external tick line, counting up or down as the shared control word selects. When a counter passes its end of range it reloads and can flag an overflow. When it passes a compare value it flags a match.

The flags of all three counters collect in one status word, which software clears by writing ones to it. A mask word then filters the status into a single interrupt line. A build parameter chooses between two packings of the per-counter control fields inside the control word. This lets one design serve software written for either packing.

Top module: `tmr3_match`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Counter n (n = 0..2) owns the 16-byte window at 16·n. The live count is at +0x0, the reload value at +0x4, compare A at +0x8 and compare B at +0xC. Control is at 0x30, status at 0x34 and mask at 0x38. A write completes in the cycle where `psel`, `penable` and `pwrite` are all high, and the reload and compare registers read back what was written.
- R3: With `ALT_LAYOUT`=0, counter n uses bit 3n as run enable, bit 3n+1 as source select (0 = bus clock, 1 = external tick) and bit 3n+2 as overflow-flag enable. Bit 9 set makes every counter count up. A control write takes effect from the next clock edge, and a stopped counter holds its value.
- R4: With `ALT_LAYOUT`=1, the same three fields of counter n sit at bits 4n, 4n+1 and 4n+2, and the count-up bit is bit 12. Bit 3 then starts nothing.
- R5: On each tick a running counter decrements, or increments in count-up mode. A write to the live count loads the value directly and takes priority over a tick in the same cycle.
- R6: With external source selected, the counter takes one tick per rising edge of its `ext_tick` line after a two-stage synchroniser. It does not count bus clocks.
- R7: A tick that finds the counter at zero (down) or at all-ones (up) loads the reload value instead and raises the overflow event.
- R8: A tick whose pre-tick count equals compare A or compare B raises that compare's event. A compare value of zero therefore fires once per down-count period.
- R9: Status bits 3n, 3n+1 and 3n+2 hold counter n's compare-A, compare-B and overflow flags. The overflow flag is set only while the counter's overflow-flag enable is on, and writing 1 to a status bit clears it.
- R10: When an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R11: `irq` is the OR of all status bits whose mask bit is 0. A mask bit of 1 suppresses its status bit.
- R12: A stopped counter raises no events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write access |
| paddr | input | 6 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from `paddr` |
| ext_tick | input | 3 | Asynchronous external tick per counter |
| irq | output | 1 | Combined interrupt request |

## Verification
Two things can land on the same status bit in one cycle: a compare hit from a running counter and a write-1 clear from the bus. The bench starts a counter so that its pre-tick count equals compare A on exactly the edge where a status clear completes. It then requires the flag to read back as set. Every other run is judged against a tick-by-tick arithmetic model of count, reload and events.

// File: rtl/tmr_pkg.sv
// Shared constants for the triple timer: register offsets and the
// position of each control field under both control-word packings.
// Assumes at most three counters, since the shared registers occupy the
// fourth window.
package tmr_pkg;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] A_CTRL = 6'h30;
    localparam logic [ADDR_W-1:0] A_STS  = 6'h34;
    localparam logic [ADDR_W-1:0] A_MASK = 6'h38;

    // Bit index of the run enable of counter n.
    function automatic int en_bit(input bit alt, input int n);
        return alt ? 4 * n : 3 * n;
    endfunction

    // Bit index of the source select of counter n.
    function automatic int src_bit(input bit alt, input int n);
        return en_bit(alt, n) + 1;
    endfunction

    // Bit index of the overflow-flag enable of counter n.
    function automatic int ovf_bit(input bit alt, input int n);
        return en_bit(alt, n) + 2;
    endfunction

    // Bit index of the shared count-up selector.
    function automatic int up_bit(input bit alt);
        return alt ? 12 : 9;
    endfunction
endpackage

// File: rtl/tmr_edge.sv
// Synchronises N asynchronous tick lines with two flops and emits a
// one-cycle pulse per rising edge. Assumes each input stays high and low
// for at least two clock cycles.
module tmr_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise
);
    logic [N-1:0] s1, s2, s3;

    // Synchroniser chain plus the delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
            s3 <= '0;
        end else begin
            s1 <= din;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rise = s2 & ~s3;
endmodule

// File: rtl/tmr_chan.sv
// One counter with its reload and two compare registers. It advances when
// run is high and tick_ok is high, reloads on wrap, and reports the
// compare-A, compare-B and wrap events of the ticking cycle.
// Assumes that the register writes are already decoded.
module tmr_chan #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          up,
    input  logic          tick_ok,
    input  logic          wr_cnt,
    input  logic          wr_load,
    input  logic          wr_cmpa,
    input  logic          wr_cmpb,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] load,
    output logic [CW-1:0] cmpa,
    output logic [CW-1:0] cmpb,
    output logic [2:0]    evt
);
    logic          step;
    logic          wrap;
    logic [CW-1:0] nxt;

    // Decide whether this cycle ticks, whether it wraps, and the next value.
    always_comb begin
        step = run && tick_ok && !wr_cnt;
        wrap = up ? (cnt == {CW{1'b1}}) : (cnt == '0);
        if (wrap)    nxt = load;
        else if (up) nxt = cnt + 1'b1;
        else         nxt = cnt - 1'b1;
    end

    // Events compare the pre-tick count.
    assign evt = {step && wrap, step && (cnt == cmpb), step && (cnt == cmpa)};

    // Counter: a direct write wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (wr_cnt)  cnt <= wdata;
        else if (step)    cnt <= nxt;
    end

    // Reload and compare registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load <= '0;
            cmpa <= '0;
            cmpb <= '0;
        end else begin
            if (wr_load) load <= wdata;
            if (wr_cmpa) cmpa <= wdata;
            if (wr_cmpb) cmpb <= wdata;
        end
    end

    // A counter write lands exactly.
    assert_cnt_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt == $past(wdata));
    // A stopped counter holds its value.
    assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> $stable(cnt));
    // A down-count at zero reloads.
    assert_down_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_ok && !wr_cnt && !up && cnt == '0) |=> cnt == $past(load));
endmodule

// File: rtl/tmr3_match.sv
// Register front end of the triple timer: decodes bus writes, holds the
// control, status and mask words, feeds the counters and drives irq.
// Assumes NUM_TMR <= 3, with the shared registers in the fourth window.
module tmr3_match
    import tmr_pkg::*;
#(
    parameter int NUM_TMR    = 3,
    parameter int CW         = 32,
    parameter bit ALT_LAYOUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [CW-1:0]     pwdata,
    output logic [CW-1:0]     prdata,
    input  logic [NUM_TMR-1:0] ext_tick,
    output logic              irq
);
    localparam int STS_W = 3 * NUM_TMR;
    localparam int UPB   = up_bit(ALT_LAYOUT);

    logic             wr_go;
    logic [1:0]       win;
    logic [1:0]       sub;
    logic [CW-1:0]    ctrl;
    logic [STS_W-1:0] sts;
    logic [STS_W-1:0] msk;
    logic [STS_W-1:0] evt_q;
    logic [STS_W-1:0] clr;
    logic [NUM_TMR-1:0] rise;
    logic [NUM_TMR-1:0] run_v;
    logic [CW-1:0] cnt_a  [NUM_TMR];
    logic [CW-1:0] load_a [NUM_TMR];
    logic [CW-1:0] cmpa_a [NUM_TMR];
    logic [CW-1:0] cmpb_a [NUM_TMR];

    assign wr_go = psel && penable && pwrite && (paddr[1:0] == 2'b00);
    assign win   = paddr[5:4];
    assign sub   = paddr[3:2];

    tmr_edge #(.N(NUM_TMR)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(ext_tick), .rise(rise)
    );

    for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
        localparam int PE = en_bit(ALT_LAYOUT, g);
        localparam int PS = src_bit(ALT_LAYOUT, g);
        localparam int PO = ovf_bit(ALT_LAYOUT, g);
        logic       hit;
        logic [2:0] evt;

        assign hit      = wr_go && (win == 2'(g));
        assign run_v[g] = ctrl[PE];

        tmr_chan #(.CW(CW)) u_chan (
            .clk(clk), .rst_n(rst_n),
            .run(ctrl[PE]), .up(ctrl[UPB]),
            .tick_ok(ctrl[PS] ? rise[g] : 1'b1),
            .wr_cnt(hit && sub == 2'd0), .wr_load(hit && sub == 2'd1),
            .wr_cmpa(hit && sub == 2'd2), .wr_cmpb(hit && sub == 2'd3),
            .wdata(pwdata),
            .cnt(cnt_a[g]), .load(load_a[g]), .cmpa(cmpa_a[g]), .cmpb(cmpb_a[g]),
            .evt(evt)
        );

        // The overflow flag is qualified by its enable.
        assign evt_q[3*g +: 3] = {evt[2] && ctrl[PO], evt[1:0]};

        // A stopped counter sets no status bit.
        assert_stop_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl[PE] |=> (sts[3*g +: 3] & ~$past(sts[3*g +: 3])) == 3'b000);
        // Without its enable, the overflow flag never rises.
        assert_ovf_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !ctrl[PO] |=> !(sts[3*g+2] && !$past(sts[3*g+2])));
    end

    assign clr = (wr_go && paddr == A_STS) ? pwdata[STS_W-1:0] : '0;

    // Control and mask words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            msk  <= '0;
        end else begin
            if (wr_go && paddr == A_CTRL) ctrl <= pwdata;
            if (wr_go && paddr == A_MASK) msk  <= pwdata[STS_W-1:0];
        end
    end

    // Status: a new event wins over a write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sts <= '0;
        else        sts <= (sts & ~clr) | evt_q;
    end

    assign irq = |(sts & ~msk);

    // Read mux.
    always_comb begin
        prdata = '0;
        if (int'(win) < NUM_TMR) begin
            case (sub)
                2'd0:    prdata = cnt_a[win];
                2'd1:    prdata = load_a[win];
                2'd2:    prdata = cmpa_a[win];
                default: prdata = cmpb_a[win];
            endcase
        end else if (paddr == A_CTRL) begin
            prdata = ctrl;
        end else if (paddr == A_STS) begin
            prdata = CW'(sts);
        end else if (paddr == A_MASK) begin
            prdata = CW'(msk);
        end
    end

    for (genvar b = 0; b < STS_W; b++) begin : g_sts
        // A write-1 clear with no event leaves the bit clear.
        assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[b] && !evt_q[b]) |=> !sts[b]);
    end

    // The interrupt line needs at least one status bit.
    assert_irq_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> sts != '0);
    // No counter runs on a cycle after reset with nothing written.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (run_v == '0 && !irq));
endmodule

// File: tb/sim_tmr3_match.sv
`timescale 1ns/1ps
module sim_tmr3_match;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  psel_d = 2'b00;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [5:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prd0, prd1;
    logic [2:0]  ext0 = '0;
    logic [2:0]  ext1 = '0;
    logic        irq0, irq1;
    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr3_match #(.ALT_LAYOUT(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel_d[0]), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prd0), .ext_tick(ext0), .irq(irq0));
    tmr3_match #(.ALT_LAYOUT(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .psel(psel_d[1]), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prd1), .ext_tick(ext1), .irq(irq1));

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // Two-phase bus write; entered and left at a falling edge.
    task automatic wr(input int d, input logic [5:0] a, input logic [31:0] v);
        psel_d[d] = 1'b1; pwrite = 1'b1; paddr = a; pwdata = v; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel_d = 2'b00; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input int d, input logic [5:0] a, output logic [31:0] v);
        paddr = a;
        #0.5;
        v = (d == 1) ? prd1 : prd0;
    endtask

    function automatic logic [31:0] ctl(input bit alt, input int n, input bit en,
                                        input bit src, input bit ov, input bit up);
        logic [31:0] c = '0;
        int base = alt ? 4 * n : 3 * n;
        c[base] = en; c[base+1] = src; c[base+2] = ov;
        c[alt ? 12 : 9] = up;
        return c;
    endfunction

    // Tick-by-tick model of one counter.
    function automatic void model(input bit up, input logic [31:0] c0, ld, ma, mb,
                                  input int t, output logic [31:0] c, output logic [2:0] ev);
        c = c0; ev = '0;
        for (int i = 0; i < t; i++) begin
            bit wrp = up ? (c == 32'hFFFF_FFFF) : (c == 0);
            if (c == ma) ev[0] = 1'b1;
            if (c == mb) ev[1] = 1'b1;
            if (wrp) ev[2] = 1'b1;
            c = wrp ? ld : (up ? c + 1 : c - 1);
        end
    endfunction

    // Enable timer n, wait k falling edges, stop it: k+2 ticks (R3 timing).
    task automatic run_tmr(input int d, input int n, input int k, input bit ov, input bit up);
        wr(d, 6'h30, ctl(d == 1, n, 1'b1, 1'b0, ov, up));
        repeat (k) @(negedge clk);
        wr(d, 6'h30, 32'h0);
    endtask

    task automatic setup(input int n, input logic [31:0] c0, ld, ma, mb);
        wr(0, 6'(16*n + 0), c0);
        wr(0, 6'(16*n + 4), ld);
        wr(0, 6'(16*n + 8), ma);
        wr(0, 6'(16*n + 12), mb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, ec;
        logic [2:0] ev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        for (int a = 0; a < 60; a += 4) begin
            rd(0, 6'(a), v); chk("R1 reset reg", v, 32'h0);
        end
        chk("R1 reset irq", {31'b0, irq0}, 32'h0);

        // R2: readback of reload and compare registers
        for (int n = 0; n < 3; n++) begin
            setup(n, 32'h0, 32'hA0 + n, 32'hB0 + n, 32'hC0 + n);
            rd(0, 6'(16*n + 4), v);  chk("R2 reload", v, 32'hA0 + n);
            rd(0, 6'(16*n + 8), v);  chk("R2 cmpA", v, 32'hB0 + n);
            rd(0, 6'(16*n + 12), v); chk("R2 cmpB", v, 32'hC0 + n);
        end

        // R3 R5 R12: each timer, both directions, others stay stopped
        for (int n = 0; n < 3; n++) begin
            for (int up = 0; up < 2; up++) begin
                for (int j = 0; j < 3; j++) setup(j, 32'd1000 + j, 32'd0, 32'd0, 32'd0);
                run_tmr(0, n, 5, 1'b0, up[0]);
                for (int j = 0; j < 3; j++) begin
                    rd(0, 6'(16*j), v);
                    if (j == n) begin
                        model(up[0], 32'd1000 + j, 0, 0, 0, 7, ec, ev);
                        chk("R5 count step", v, ec);
                    end else begin
                        chk("R3 stopped holds", v, 32'd1000 + j);
                    end
                end
                rd(0, 6'h34, v); chk("R12 no events", v, 32'h0);
            end
        end

        // R7 R8 R9: down wrap with zero compares, with and without the flag enable
        for (int n = 0; n < 3; n++) begin
            for (int ov = 0; ov < 2; ov++) begin
                setup(n, 32'd2, 32'd10, 32'd0, 32'd0);
                run_tmr(0, n, 3, ov[0], 1'b0);
                model(1'b0, 32'd2, 32'd10, 0, 0, 5, ec, ev);
                rd(0, 6'(16*n), v); chk("R7 down reload", v, ec);
                rd(0, 6'h34, v);
                chk("R9 status bits", v, 32'({ev[2] & ov[0], ev[1:0]}) << (3*n));
                wr(0, 6'h34, 32'h1FF);
                rd(0, 6'h34, v); chk("R9 w1c", v, 32'h0);
            end
            // up wrap
            setup(n, 32'hFFFF_FFFE, 32'd5, 32'd0, 32'd0);
            run_tmr(0, n, 3, 1'b1, 1'b1);
            model(1'b1, 32'hFFFF_FFFE, 32'd5, 0, 0, 5, ec, ev);
            rd(0, 6'(16*n), v); chk("R7 up reload", v, ec);
            rd(0, 6'h34, v); chk("R7 up overflow flag", v, 32'(ev) << (3*n));
            wr(0, 6'h34, 32'h1FF);
        end

        // R8 R11: compare A hit, compare B missed, then masking
        for (int n = 0; n < 3; n++) begin
            setup(n, 32'd20, 32'd0, 32'd17, 32'd3);
            run_tmr(0, n, 3, 1'b0, 1'b0);
            model(1'b0, 32'd20, 0, 17, 3, 5, ec, ev);
            rd(0, 6'h34, v); chk("R8 compare events", v, 32'(ev) << (3*n));
            chk("R11 irq unmasked", {31'b0, irq0}, 32'h1);
            wr(0, 6'h38, 32'h1 << (3*n));
            #0.5; chk("R11 irq masked", {31'b0, irq0}, 32'h0);
            wr(0, 6'h38, 32'h0);
            #0.5; chk("R11 irq unmasked again", {31'b0, irq0}, 32'h1);
            wr(0, 6'h34, 32'h1 << (3*n));
            #0.5; chk("R9 irq after w1c", {31'b0, irq0}, 32'h0);
        end

        // R10: compare hit and status clear on the same edge
        setup(1, 32'd50, 32'd0, 32'd49, 32'd7);
        wr(0, 6'h30, ctl(0, 1, 1'b1, 1'b0, 1'b0, 1'b0));
        wr(0, 6'h34, 32'h1 << 3);
        wr(0, 6'h30, 32'h0);
        rd(0, 6'h34, v); chk("R10 set wins over clear", v, 32'h1 << 3);
        wr(0, 6'h34, 32'h1FF);

        // R6: external tick source
        setup(2, 32'd100, 32'd0, 32'd0, 32'd0);
        wr(0, 6'h30, ctl(0, 2, 1'b1, 1'b1, 1'b0, 1'b0));
        for (int p = 0; p < 4; p++) begin
            ext0[2] = 1'b1; repeat (3) @(negedge clk);
            ext0[2] = 1'b0; repeat (3) @(negedge clk);
        end
        repeat (4) @(negedge clk);
        wr(0, 6'h30, 32'h0);
        rd(0, 6'h20, v); chk("R6 external ticks", v, 32'd96);

        // R4: alternate packing on the second instance
        wr(1, 6'h10, 32'd0);
        run_tmr(1, 1, 3, 1'b0, 1'b1);
        rd(1, 6'h10, v); chk("R4 alt enable and up", v, 32'd5);
        wr(1, 6'h00, 32'd40);
        wr(1, 6'h30, 32'h8);
        repeat (4) @(negedge clk);
        wr(1, 6'h30, 32'h0);
        rd(1, 6'h00, v); chk("R4 bit3 unused in alt", v, 32'd40);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule